// File: doc/BRIEF.md
# Stateful Implication Adder Sequencer

This block adds binary numbers using nothing but two operations on a small bank of single-bit storage cells. The first operation is an unconditional clear, which forces one cell to 0. The second is an in-place implication: a target cell is overwritten with (NOT source) OR target, and the source cell keeps its value. No ordinary gate ever combines data bits. Every sum and carry bit is produced inside the cells themselves.

A micro-sequencer executes one of these operations per clock cycle. It reads them from a small macro table. Each macro expands into either a two-step inverter or a three-step NAND. One program computes a full adder and a shorter one computes a half adder. A word-wide ripple-carry add runs the full-adder program once per bit, starting at the least significant bit, and leaves each carry in place for the next bit. A fourth command issues a single raw operation, so that the cells can be set up and inspected directly. The host raises `start` with a command code and the operands, watches `busy`, and reads the results when the one-cycle `done` pulse appears. Two counters report how many clears and how many implications the last command performed.

The bank has eight cells. Cells 0 to 5 are working storage. Cells 6 and 7 are permanently 0: they may be read as a constant-0 source but are never written. Operands are loaded with cell 0 = a and cell 1 = b, and cell 2 = carry-in for the first bit only. Every arithmetic program leaves the sum in cell 0 and the carry in cell 2.

Top module: `imp_adder_seq`

## Requirements
- R1: With `mode` = 2'b11 and `prim_imp` = 1, the cell at `prim_dst` becomes (NOT cell[`prim_src`]) OR cell[`prim_dst`]. All other cells, including the source, keep their values. `done` rises 1 clock edge after the edge that accepts `start`.
- R2: With `mode` = 2'b11 and `prim_imp` = 0, the cell at `prim_dst` becomes 0 whatever its previous value, and no other cell changes.
- R3: The full-adder program performs exactly 13 clears and 22 implications, and the half-adder program exactly 5 clears and 9 implications. `rst_cnt` and `imp_cnt` report these counts at `done`, cleared at each accepted start.
- R4: With `mode` = 2'b00, the inputs are a = `op_a[0]`, b = `op_b[0]` and carry-in = `cin`. At `done`, `sum_o` = {0…, a^b^cin} and `cout_o` = majority(a, b, cin), where `cout_o` mirrors cell 2. `done` rises 37 edges after the accepting edge.
- R5: With `mode` = 2'b01, the inputs are a = `op_a[0]` and b = `op_b[0]`. At `done`, `sum_o` = {0…, a^b} and `cout_o` = a AND b. `done` rises 16 edges after the accepting edge.
- R6: With `mode` = 2'b10, `{cout_o, sum_o}` = `op_a` + `op_b` + `cin` (ripple carry, least significant bit first). At the default WIDTH of 8, `done` rises 296 edges after the accepting edge, with 104 clears and 176 implications counted.
- R7: Cells 6 and 7 read 0 at all times. An implication that uses one of them as its source sets the target to 1.
- R8: A raw operation whose target is cell 6 or 7 leaves every cell unchanged, counts no step and sets `err_o`. `err_o` clears at the next accepted start.
- R9: `start` is ignored while `busy` is high. The running command's results, counts and latency are unaffected, and no extra `done` follows.
- R10: After reset, `busy`, `done`, `err_o`, `cout_o`, `sum_o`, `cells_o` and both counters are 0.
- R11: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` is a pulse one cycle long, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, accepted when idle |
| mode | input | 2 | 00 full add, 01 half add, 10 word add, 11 raw operation |
| op_a | input | WIDTH | First operand (bit 0 only for the single-bit modes) |
| op_b | input | WIDTH | Second operand (bit 0 only for the single-bit modes) |
| cin | input | 1 | Carry-in for full add and word add |
| prim_imp | input | 1 | Raw operation kind: 1 implication, 0 clear |
| prim_src | input | 3 | Raw operation source cell |
| prim_dst | input | 3 | Raw operation target cell |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_o | output | WIDTH | Sum bits collected from cell 0 |
| cout_o | output | 1 | Carry, the live value of cell 2 |
| cells_o | output | 8 | Live contents of the cell bank |
| rst_cnt | output | CNT_W | Clears performed by the last command |
| imp_cnt | output | CNT_W | Implications performed by the last command |
| err_o | output | 1 | Write to a constant-0 cell was refused |

## Verification
Raw operations are tried first, starting from all-zero cells, so that each outcome can be traced by hand:
- An implication from a constant-0 cell sets its target.
- An implication from a set cell leaves a set target unchanged.
- A clear acts on a cell that already holds 0.
- A write aimed at a constant-0 cell is refused.

Together these separate correct implication semantics from a plain copy, a plain inversion, or an unguarded write. The full adder is then driven with all eight input combinations, which tells apart errors in the sum path from errors in the carry path. The half adder is driven with all four input combinations.

The word add is run with patterns chosen to exercise different parts of the carry chain:
- An all-ones operand plus one ripples a carry through every bit.
- Alternating bit patterns with a carry-in likewise ripple through every bit.
- Two top-bit-only operands produce a carry out of the top bit only.
- An all-zero add confirms that nothing leaks in.

Random operand pairs follow. One further add has a second `start` pulsed while it runs.

// File: rtl/imp_adder_seq.sv
module imp_adder_seq #(
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(WIDTH * 35 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  input  logic             prim_imp,
  input  logic [2:0]       prim_src,
  input  logic [2:0]       prim_dst,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [7:0]       cells_o,
  output logic [CNT_W-1:0] rst_cnt,
  output logic [CNT_W-1:0] imp_cnt,
  output logic             err_o
);

  localparam int         BIT_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [2:0] FIRST_OFF = 3'd6;
  localparam logic [3:0] FA_LAST   = 4'd12;
  localparam logic [3:0] HA_SPLIT  = 4'd3;
  localparam logic [3:0] HA_TAIL   = 4'd13;
  localparam logic [1:0] M_FA = 2'd0, M_HA = 2'd1, M_ADD = 2'd2, M_PRIM = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RUN, S_STORE, S_PRIM} state_t;

  // entry = {is_nand, src1, src2, dst}; 0..12 full adder, 13 half-adder carry
  function automatic logic [9:0] macro_rom(input logic [3:0] idx);
    case (idx)
      4'd0:    macro_rom = {1'b1, 3'd0, 3'd1, 3'd3};
      4'd1:    macro_rom = {1'b1, 3'd0, 3'd3, 3'd4};
      4'd2:    macro_rom = {1'b1, 3'd1, 3'd3, 3'd5};
      4'd3:    macro_rom = {1'b1, 3'd4, 3'd5, 3'd0};
      4'd4:    macro_rom = {1'b1, 3'd0, 3'd2, 3'd1};
      4'd5:    macro_rom = {1'b1, 3'd0, 3'd1, 3'd4};
      4'd6:    macro_rom = {1'b1, 3'd2, 3'd1, 3'd5};
      4'd7:    macro_rom = {1'b1, 3'd4, 3'd5, 3'd0};
      4'd8:    macro_rom = {1'b1, 3'd3, 3'd1, 3'd4};
      4'd9:    macro_rom = {1'b0, 3'd4, 3'd0, 3'd5};
      4'd10:   macro_rom = {1'b0, 3'd5, 3'd0, 3'd2};
      4'd11:   macro_rom = {1'b0, 3'd0, 3'd0, 3'd1};
      4'd12:   macro_rom = {1'b0, 3'd1, 3'd0, 3'd0};
      4'd13:   macro_rom = {1'b0, 3'd3, 3'd0, 3'd2};
      default: macro_rom = '0;
    endcase
  endfunction

  state_t           st;
  logic [3:0]       mac;
  logic [1:0]       ph;
  logic [BIT_W-1:0] bit_q;
  logic [1:0]       mode_q;
  logic [WIDTH-1:0] a_q, b_q, sum_q;
  logic             cin_q, p_imp_q, done_q, err_q;
  logic [2:0]       p_src_q, p_dst_q;
  logic [7:0]       cell_q;
  logic [CNT_W-1:0] rcnt, icnt;

  logic [9:0] ent;
  logic       ex_v, ex_imp;
  logic [2:0] ex_src, ex_dst;

  assign ent = macro_rom(mac);

  always_comb begin
    if (st == S_PRIM) begin
      ex_v   = 1'b1;
      ex_imp = p_imp_q;
      ex_src = p_src_q;
      ex_dst = p_dst_q;
    end else begin
      ex_v   = (st == S_RUN);
      ex_imp = (ph != 2'd0);
      ex_src = (ph == 2'd2) ? ent[5:3] : ent[8:6];
      ex_dst = ent[2:0];
    end
  end

  wire       blocked  = ex_dst >= FIRST_OFF;
  wire       wr_ok    = ex_v && !blocked;
  wire       mac_end  = ph == (ent[9] ? 2'd2 : 2'd1);
  wire       prog_end = mac_end && ((mode_q == M_HA) ? (mac == HA_TAIL) : (mac == FA_LAST));
  wire [3:0] next_mac = (mode_q == M_HA && mac == HA_SPLIT) ? HA_TAIL : mac + 4'd1;
  wire       last_bit = (mode_q != M_ADD) || (bit_q == BIT_W'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mac     <= '0;
      ph      <= '0;
      bit_q   <= '0;
      mode_q  <= M_FA;
      a_q     <= '0;
      b_q     <= '0;
      cin_q   <= 1'b0;
      p_imp_q <= 1'b0;
      p_src_q <= '0;
      p_dst_q <= '0;
      cell_q  <= '0;
      rcnt    <= '0;
      icnt    <= '0;
      sum_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_ok) begin
        cell_q[ex_dst] <= ex_imp ? (~cell_q[ex_src] | cell_q[ex_dst]) : 1'b0;
        if (ex_imp) icnt <= icnt + 1'b1;
        else        rcnt <= rcnt + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          mode_q  <= mode;
          a_q     <= op_a;
          b_q     <= op_b;
          cin_q   <= cin;
          p_imp_q <= prim_imp;
          p_src_q <= prim_src;
          p_dst_q <= prim_dst;
          rcnt    <= '0;
          icnt    <= '0;
          sum_q   <= '0;
          err_q   <= 1'b0;
          bit_q   <= '0;
          st      <= (mode == M_PRIM) ? S_PRIM : S_LOAD;
        end
        S_LOAD: begin
          cell_q[0] <= a_q[bit_q];
          cell_q[1] <= b_q[bit_q];
          if (bit_q == '0) cell_q[2] <= cin_q;
          mac <= '0;
          ph  <= '0;
          st  <= S_RUN;
        end
        S_RUN: begin
          if (mac_end) begin
            ph <= '0;
            if (prog_end) st <= S_STORE;
            else          mac <= next_mac;
          end else begin
            ph <= ph + 2'd1;
          end
        end
        S_STORE: begin
          sum_q[bit_q] <= cell_q[0];
          if (last_bit) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            st    <= S_LOAD;
          end
        end
        S_PRIM: begin
          if (blocked) err_q <= 1'b1;
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign sum_o   = sum_q;
  assign cout_o  = cell_q[2];
  assign cells_o = cell_q;
  assign rst_cnt = rcnt;
  assign imp_cnt = icnt;
  assign err_o   = err_q;

  p_imp_src_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ex_imp && ex_src != ex_dst) |=> cell_q[$past(ex_src)] == $past(cell_q[ex_src]));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !ex_imp) |=> !cell_q[$past(ex_dst)]);

  p_fa_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && mode_q == M_FA) |-> (rcnt == CNT_W'(13) && icnt == CNT_W'(22)));

  p_add_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && mode_q == M_ADD) |->
      (rcnt == CNT_W'(13 * (int'(bit_q) + 1)) && icnt == CNT_W'(22 * (int'(bit_q) + 1))));

  p_off_cells_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_q[7:6] == 2'b00);

  p_blocked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && blocked) |=> ($stable(cell_q) && err_q));

  p_busy_holds_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_PRIM) |=> ($stable(mode_q) && $stable(a_q) && $stable(b_q)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

endmodule

// File: tb/imp_adder_seq_tb.sv
`timescale 1ns/1ps
module imp_adder_seq_tb;
  localparam int W  = 8;
  localparam int CW = $clog2(W * 35 + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [W-1:0]  op_a = '0, op_b = '0;
  logic          cin = 1'b0, prim_imp = 1'b0;
  logic [2:0]    prim_src = '0, prim_dst = '0;
  logic          busy, done, cout_o, err_o;
  logic [W-1:0]  sum_o;
  logic [7:0]    cells_o;
  logic [CW-1:0] rst_cnt, imp_cnt;

  imp_adder_seq #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_a(op_a), .op_b(op_b),
    .cin(cin), .prim_imp(prim_imp), .prim_src(prim_src), .prim_dst(prim_dst),
    .busy(busy), .done(done), .sum_o(sum_o), .cout_o(cout_o), .cells_o(cells_o),
    .rst_cnt(rst_cnt), .imp_cnt(imp_cnt), .err_o(err_o));

  always #2 clk = ~clk;

  typedef struct packed {
    logic [W-1:0]  sum;
    logic          cout;
    logic [CW-1:0] rc;
    logic [CW-1:0] ic;
    logic [15:0]   lat;
    logic          chk_cells;
    logic [7:0]    cells;
    logic          err;
  } exp_t;

  exp_t   q[$];
  string  qreq[$];
  exp_t   cur;
  string  cur_req;
  int     cyc = 0, start_cyc = 0, checks = 0, errors = 0;
  logic [7:0] mcell = '0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [W-1:0] s, input logic co, input int rc, input int ic,
                              input int lat, input logic cc, input logic [7:0] cl, input logic er);
    exp_t e;
    e.sum = s; e.cout = co; e.rc = CW'(rc); e.ic = CW'(ic); e.lat = 16'(lat);
    e.chk_cells = cc; e.cells = cl; e.err = er;
    return e;
  endfunction

  // monitor: pops the scoreboard at every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        cur = q.pop_front();
        cur_req = qreq.pop_front();
        chk(sum_o == cur.sum, cur_req, "sum", sum_o, cur.sum);
        chk(cout_o == cur.cout, cur_req, "carry", cout_o, cur.cout);
        chk(rst_cnt == cur.rc, cur_req, "clear count", rst_cnt, cur.rc);
        chk(imp_cnt == cur.ic, cur_req, "implication count", imp_cnt, cur.ic);
        chk((cyc - start_cyc) == int'(cur.lat), cur_req, "latency", cyc - start_cyc, cur.lat);
        chk(err_o == cur.err, cur_req, "error flag", err_o, cur.err);
        if (cur.chk_cells) chk(cells_o == cur.cells, cur_req, "cells", cells_o, cur.cells);
        chk(cells_o[7:6] == 2'b00, "R7", "constant cells", cells_o[7:6], 0);
      end
    end
  end

  task automatic run_op(input logic [1:0] md, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input logic pi, input logic [2:0] ps, input logic [2:0] pd,
                        input exp_t e, input string r, input bit interfere);
    q.push_back(e);
    qreq.push_back(r);
    @(negedge clk);
    mode = md; op_a = a; op_b = b; cin = c; prim_imp = pi; prim_src = ps; prim_dst = pd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
    if (interfere) begin
      repeat (5) @(negedge clk);
      mode = 2'd0; op_a = ~a; op_b = ~b; cin = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9", "busy during ignored start", busy, 1);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R11", "done pulse width / idle", {done, busy}, 0);
  endtask

  task automatic prim(input logic pi, input logic [2:0] ps, input logic [2:0] pd, input string r);
    logic blk;
    blk = (pd >= 3'd6);
    if (!blk) mcell[pd] = pi ? (~mcell[ps] | mcell[pd]) : 1'b0;
    run_op(2'd3, '0, '0, 1'b0, pi, ps, pd,
           mk('0, mcell[2], (!pi && !blk) ? 1 : 0, (pi && !blk) ? 1 : 0, 1, 1'b1, mcell, blk),
           r, 1'b0);
  endtask

  task automatic fa(input logic a, input logic b, input logic c);
    logic s, co;
    s  = a ^ b ^ c;
    co = (a & b) | (c & (a ^ b));
    run_op(2'd0, W'(a), W'(b), c, 1'b0, '0, '0,
           mk(W'(s), co, 13, 22, 37, 1'b0, '0, 1'b0), "R3 R4", 1'b0);
  endtask

  task automatic ha(input logic a, input logic b);
    run_op(2'd1, W'(a), W'(b), 1'b0, 1'b0, '0, '0,
           mk(W'(a ^ b), a & b, 5, 9, 16, 1'b0, '0, 1'b0), "R3 R5", 1'b0);
  endtask

  task automatic add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                     input bit interfere, input string r);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b} + (W+1)'(c);
    run_op(2'd2, a, b, c, 1'b0, '0, '0,
           mk(t[W-1:0], t[W], 13 * W, 22 * W, 37 * W, 1'b0, '0, 1'b0), r, interfere);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err_o, "R10", "control outputs", {busy, done, err_o}, 0);
    chk(cells_o == 8'h00 && !cout_o, "R10", "cells", cells_o, 0);
    chk(sum_o == '0 && rst_cnt == '0 && imp_cnt == '0, "R10", "sum/counters",
        {sum_o, rst_cnt, imp_cnt}, 0);

    prim(1'b1, 3'd6, 3'd3, "R7");
    prim(1'b1, 3'd3, 3'd4, "R1");
    prim(1'b1, 3'd4, 3'd5, "R1");
    prim(1'b1, 3'd3, 3'd5, "R1");
    prim(1'b1, 3'd7, 3'd2, "R7");
    prim(1'b0, 3'd3, 3'd3, "R2");
    prim(1'b0, 3'd0, 3'd4, "R2");
    prim(1'b0, 3'd0, 3'd6, "R8");
    prim(1'b1, 3'd0, 3'd7, "R8");
    prim(1'b1, 3'd5, 3'd1, "R8");

    for (int i = 0; i < 8; i++) fa(i[2], i[1], i[0]);
    for (int i = 0; i < 4; i++) ha(i[1], i[0]);

    add(8'h00, 8'h00, 1'b0, 1'b0, "R6");
    add(8'hFF, 8'h01, 1'b0, 1'b0, "R6");
    add(8'hFF, 8'hFF, 1'b1, 1'b0, "R6");
    add(8'h80, 8'h80, 1'b0, 1'b0, "R6");
    add(8'h55, 8'hAA, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 12; i++) add(W'($urandom), W'($urandom), 1'($urandom), 1'b0, "R6");
    add(8'h3C, 8'h47, 1'b1, 1'b1, "R9");

    repeat (60) @(negedge clk);
    chk(q.size() == 0 && !busy, "R9", "no extra command", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule